// File: doc/BRIEF.md
# Serial Bank Register Loader

This block sits on a CPU write bus and builds 5-bit register values out of single-bit writes. Each accepted write in the upper half of the address space contributes data bit 0, lowest bit first; the fifth such write commits the assembled value to one of four internal registers, picked by address bits 14:13 of that fifth write. A write carrying data bit 7 aborts the sequence and forces the two bank-layout bits of the control register on.

The four registers are decoded into bank numbers for 16 KB and 32 KB program windows, for 4 KB and 8 KB pattern windows, and into a 2-bit mirroring code. A separate mode register, written in the lower address space, enables or disables the serial loader. When that write also has address bit 0 set, it returns the loader, the control register and the program register to their power-on values.

Top module: `serial_bank_loader`

## Requirements
- R1: After reset the control register is 0x0C and the other registers, the shift buffer and the bit count are zero, so the outputs read prg16_lo=0, prg16_hi=15, prg32=0, chr4_lo=0, chr4_hi=1, chr8=0, mirror=0.
- R2: With the loader enabled, a write with addr[15]=1 and wdata[7]=0 places wdata[0] at the current count position (LSB first); on the fifth such write the 5-bit value goes to register addr[14:13] of that write (0 control, 1 pattern low, 2 pattern high, 3 program) and the buffer and count clear.
- R3: With the loader enabled, a write with addr[15]=1 and wdata[7]=1 clears the buffer and count and sets control bits 3 and 2, leaving the other control bits unchanged.
- R4: Program bank b is program register bits 3:0 and prg32 is b>>1. With control bit 3 clear, prg16_lo={b[3:1],0} and prg16_hi={b[3:1],1}; with bits 3 and 2 set, prg16_lo=b and prg16_hi=15; with bit 3 set and bit 2 clear, prg16_lo=0 and prg16_hi=b.
- R5: chr8 is pattern-low register >>1. With control bit 4 set, chr4_lo and chr4_hi are the pattern-low and pattern-high registers; with it clear they are {chr8,0} and {chr8,1}.
- R6: mirror equals control bits 1:0: 0 one-screen low page, 1 one-screen high page, 2 vertical, 3 horizontal.
- R7: The loader is enabled only when mode bit 1 is set (mode 2 or 3); with it clear, writes with addr[15]=1 change neither the buffer, the count nor any register.
- R8: A write with addr[15]=0, addr[14]=1 and addr[8]=1 loads wdata into the mode register; if addr[0] is also 1, the control register becomes 0x0C, the program register 0, and the buffer and count clear, while the pattern registers keep their values.
- R9: Every output reflects a write two clock edges after the edge that samples it, and back-to-back writes on consecutive cycles are all taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle it is high |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write data |
| prg16_lo | output | 4 | 16 KB bank for the lower program window |
| prg16_hi | output | 4 | 16 KB bank for the upper program window |
| prg32 | output | 3 | 32 KB program bank |
| chr4_lo | output | 5 | 4 KB bank for the lower pattern window |
| chr4_hi | output | 5 | 4 KB bank for the upper pattern window |
| chr8 | output | 4 | 8 KB pattern bank |
| mirror | output | 2 | Mirroring code |

## Verification
A write sampled at one rising edge updates the register state at that edge and the registered outputs at the next, so each result is due on the second edge after the cycle in which the write is driven. The driver stamps every expected output word with that cycle number as it drives the write, and the monitor compares on the falling edge of exactly that cycle, which lets writes run back to back while the comparisons trail two cycles behind. Writes that must be ignored get the same stamped check, so a change that should not happen is seen at the outputs.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  // Mirroring codes carried on the mirror output
  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  // Control register field positions
  localparam int CTL_PRG_SPLIT = 3;  // 16 KB windows when set
  localparam int CTL_PRG_LOSW  = 2;  // lower window switchable when set
  localparam int CTL_CHR_SPLIT = 4;  // two 4 KB pattern windows when set
  localparam logic [4:0] CTL_RESET = 5'h0C;
endpackage

// File: rtl/sbl_mode_reg.sv
module sbl_mode_reg #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] mode_q,
  output logic              hard_clr,
  output logic              ser_wr
);
  logic mode_hit;

  assign mode_hit = wr_en && !addr[ADDR_W-1] && addr[ADDR_W-2] && addr[8];
  assign hard_clr = mode_hit && addr[0];
  assign ser_wr   = wr_en && addr[ADDR_W-1] && mode_q[1];

  always_ff @(posedge clk) begin
    if (rst)           mode_q <= '0;
    else if (mode_hit) mode_q <= wdata;
  end
endmodule

// File: rtl/sbl_shifter.sv
module sbl_shifter #(
  parameter int SHIFT_LEN = 5,
  parameter int CNT_W     = $clog2(SHIFT_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ser_wr,
  input  logic                 bit_in,
  input  logic                 abort_in,
  input  logic                 hard_clr,
  output logic                 commit,
  output logic                 abort,
  output logic [SHIFT_LEN-1:0] value,
  output logic [CNT_W-1:0]     bit_cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SHIFT_LEN - 1);

  logic [SHIFT_LEN-2:0] buf_q;

  assign abort  = ser_wr && abort_in;
  assign commit = ser_wr && !abort_in && (bit_cnt == LAST);
  assign value  = {bit_in, buf_q};

  always_ff @(posedge clk) begin
    if (rst || hard_clr || abort || commit) begin
      buf_q   <= '0;
      bit_cnt <= '0;
    end else if (ser_wr) begin
      for (int i = 0; i < SHIFT_LEN - 1; i++)
        if (bit_cnt == CNT_W'(i)) buf_q[i] <= bit_in;
      bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sbl_regfile.sv
module sbl_regfile
  import sbl_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            commit,
  input  logic [IDX_W-1:0]                idx,
  input  logic [REG_W-1:0]                value,
  input  logic                            abort,
  input  logic                            hard_clr,
  output logic [NUM_REGS-1:0][REG_W-1:0]  regs
);
  // Register 0: control
  always_ff @(posedge clk) begin
    if (rst || hard_clr)           regs[0] <= CTL_RESET;
    else if (abort)                regs[0] <= regs[0] | CTL_RESET;
    else if (commit && idx == '0)  regs[0] <= value;
  end

  // Banking registers; the last one (program) is also cleared by hard_clr
  for (genvar g = 1; g < NUM_REGS; g++) begin : g_bank
    localparam bit CLR_ON_MODE = (g == NUM_REGS - 1);
    always_ff @(posedge clk) begin
      if (rst || (CLR_ON_MODE && hard_clr))    regs[g] <= '0;
      else if (commit && idx == IDX_W'(g))     regs[g] <= value;
    end
  end
endmodule

// File: rtl/sbl_decode.sv
module sbl_decode
  import sbl_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int NUM_REGS = 4,
  parameter int PRG_W    = 4,
  parameter int CHR8_W   = REG_W - 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  output logic [PRG_W-1:0]               prg16_lo,
  output logic [PRG_W-1:0]               prg16_hi,
  output logic [PRG_W-2:0]               prg32,
  output logic [REG_W-1:0]               chr4_lo,
  output logic [REG_W-1:0]               chr4_hi,
  output logic [CHR8_W-1:0]              chr8,
  output logic [1:0]                     mirror
);
  logic [REG_W-1:0]  ctl;
  logic [PRG_W-1:0]  pbank;
  logic [PRG_W-1:0]  n_plo, n_phi;
  logic [REG_W-1:0]  n_clo, n_chi;
  mirror_e           n_mir;

  assign ctl   = regs[0];
  assign pbank = regs[NUM_REGS-1][PRG_W-1:0];

  always_comb begin
    if (!ctl[CTL_PRG_SPLIT]) begin
      n_plo = {pbank[PRG_W-1:1], 1'b0};
      n_phi = {pbank[PRG_W-1:1], 1'b1};
    end else if (ctl[CTL_PRG_LOSW]) begin
      n_plo = pbank;
      n_phi = '1;
    end else begin
      n_plo = '0;
      n_phi = pbank;
    end
    if (ctl[CTL_CHR_SPLIT]) begin
      n_clo = regs[1];
      n_chi = regs[2];
    end else begin
      n_clo = {regs[1][REG_W-1:1], 1'b0};
      n_chi = {regs[1][REG_W-1:1], 1'b1};
    end
    n_mir = mirror_e'(ctl[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prg16_lo <= '0;
      prg16_hi <= '1;
      prg32    <= '0;
      chr4_lo  <= '0;
      chr4_hi  <= REG_W'(1);
      chr8     <= '0;
      mirror   <= MIR_ONE_LO;
    end else begin
      prg16_lo <= n_plo;
      prg16_hi <= n_phi;
      prg32    <= pbank[PRG_W-1:1];
      chr4_lo  <= n_clo;
      chr4_hi  <= n_chi;
      chr8     <= regs[1][REG_W-1:1];
      mirror   <= n_mir;
    end
  end
endmodule

// File: rtl/serial_bank_loader.sv
module serial_bank_loader #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SHIFT_LEN = 5,
  parameter int NUM_REGS  = 4,
  parameter int PRG_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [PRG_W-1:0]     prg16_lo,
  output logic [PRG_W-1:0]     prg16_hi,
  output logic [PRG_W-2:0]     prg32,
  output logic [SHIFT_LEN-1:0] chr4_lo,
  output logic [SHIFT_LEN-1:0] chr4_hi,
  output logic [SHIFT_LEN-2:0] chr8,
  output logic [1:0]           mirror
);
  localparam int CNT_W = $clog2(SHIFT_LEN + 1);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0]                      mode_q;
  logic                                   hard_clr, ser_wr, commit, abort;
  logic [SHIFT_LEN-1:0]                   value;
  logic [CNT_W-1:0]                       bit_cnt;
  logic [NUM_REGS-1:0][SHIFT_LEN-1:0]     regs;

  sbl_mode_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .hard_clr(hard_clr), .ser_wr(ser_wr)
  );

  sbl_shifter #(.SHIFT_LEN(SHIFT_LEN), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .ser_wr(ser_wr), .bit_in(wdata[0]),
    .abort_in(wdata[DATA_W-1]), .hard_clr(hard_clr), .commit(commit),
    .abort(abort), .value(value), .bit_cnt(bit_cnt)
  );

  sbl_regfile #(.REG_W(SHIFT_LEN), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .commit(commit),
    .idx(addr[ADDR_W-2 -: IDX_W]), .value(value), .abort(abort),
    .hard_clr(hard_clr), .regs(regs)
  );

  sbl_decode #(.REG_W(SHIFT_LEN), .NUM_REGS(NUM_REGS), .PRG_W(PRG_W)) u_dec (
    .clk(clk), .rst(rst), .regs(regs), .prg16_lo(prg16_lo),
    .prg16_hi(prg16_hi), .prg32(prg32), .chr4_lo(chr4_lo),
    .chr4_hi(chr4_hi), .chr8(chr8), .mirror(mirror)
  );
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SHIFT_LEN = 5,
  parameter int NUM_REGS  = 4,
  parameter int CNT_W     = $clog2(SHIFT_LEN + 1)
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 wr_en,
  input logic [ADDR_W-1:0]                    addr,
  input logic [DATA_W-1:0]                    wdata,
  input logic [DATA_W-1:0]                    mode_q,
  input logic [CNT_W-1:0]                     bit_cnt,
  input logic [NUM_REGS-1:0][SHIFT_LEN-1:0]   regs,
  input logic [1:0]                           mirror
);
  logic up_wr, mode_a0_wr;
  assign up_wr      = wr_en && addr[ADDR_W-1];
  assign mode_a0_wr = wr_en && !addr[ADDR_W-1] && addr[ADDR_W-2] && addr[8] && addr[0];

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
    bit_cnt < CNT_W'(SHIFT_LEN)); // R2

  AST_ABORT_SETS_LAYOUT: assert property (@(posedge clk) disable iff (rst)
    (up_wr && mode_q[1] && wdata[DATA_W-1]) |=> (bit_cnt == '0 && regs[0][3:2] == 2'b11)); // R3

  AST_MIRROR_FOLLOWS_CTL: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> mirror == $past(regs[0][1:0])); // R6

  AST_LOADER_GATED: assert property (@(posedge clk) disable iff (rst)
    (up_wr && !mode_q[1]) |=> ($stable(bit_cnt) && $stable(regs))); // R7

  AST_MODE_RESTORE: assert property (@(posedge clk) disable iff (rst)
    mode_a0_wr |=> (regs[0] == 5'h0C && regs[NUM_REGS-1] == '0 && bit_cnt == '0)); // R8
endmodule

bind serial_bank_loader sbl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SHIFT_LEN(SHIFT_LEN), .NUM_REGS(NUM_REGS)
) u_sbl_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .mode_q(mode_q), .bit_cnt(bit_cnt), .regs(regs), .mirror(mirror)
);

// File: tb/serial_bank_loader_bench.sv
module serial_bank_loader_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [3:0]  prg16_lo, prg16_hi;
  logic [2:0]  prg32;
  logic [4:0]  chr4_lo, chr4_hi;
  logic [3:0]  chr8;
  logic [1:0]  mirror;

  serial_bank_loader u_serial_bank_loader (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .prg16_lo(prg16_lo), .prg16_hi(prg16_hi), .prg32(prg32),
    .chr4_lo(chr4_lo), .chr4_hi(chr4_hi), .chr8(chr8), .mirror(mirror)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int          due;
    logic [26:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  // Reference state kept from the requirements
  int m_r[4];
  int m_mode, m_buf, m_cnt;

  always @(posedge clk) cyc++;

  function automatic logic [26:0] expv();
    int b, plo, phi, clo, chi;
    b = m_r[3] & 15;
    if ((m_r[0] & 8) == 0) begin plo = b & 14; phi = b | 1; end
    else if ((m_r[0] & 4) != 0) begin plo = b; phi = 15; end
    else begin plo = 0; phi = b; end
    if ((m_r[0] & 16) != 0) begin clo = m_r[1]; chi = m_r[2]; end
    else begin clo = m_r[1] & 30; chi = m_r[1] | 1; end
    return {4'(plo), 4'(phi), 3'(b >> 1), 5'(clo), 5'(chi), 4'(m_r[1] >> 1), 2'(m_r[0] & 3)};
  endfunction

  function automatic void model(input logic [15:0] a, input logic [7:0] d);
    if (a[15]) begin
      if ((m_mode & 2) != 0) begin
        if (d[7]) begin
          m_buf = 0; m_cnt = 0; m_r[0] = m_r[0] | 12;
        end else begin
          m_buf = m_buf | (int'(d[0]) << m_cnt);
          m_cnt++;
          if (m_cnt == 5) begin
            m_r[a[14:13]] = m_buf; m_buf = 0; m_cnt = 0;
          end
        end
      end
    end else if (a[14] && a[8]) begin
      m_mode = d;
      if (a[0]) begin m_r[0] = 12; m_r[3] = 0; m_buf = 0; m_cnt = 0; end
    end
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    model(a, d);
    it.due = cyc + 2; it.exp = expv(); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic ser5(input logic [15:0] a, input int v, input string tag);
    for (int i = 0; i < 5; i++) wr(a, 8'((v >> i) & 1), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
    end
  endtask

  // Monitor: compares each expected word in the cycle it is due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      logic [26:0] got;
      it = sb.pop_front();
      got = {prg16_lo, prg16_hi, prg32, chr4_lo, chr4_hi, chr8, mirror};
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h (cycle %0d)", it.tag, got, it.exp, cyc);
      end
    end
  end

  initial begin
    item_t it;
    m_r[0] = 12; m_r[1] = 0; m_r[2] = 0; m_r[3] = 0;
    m_mode = 0; m_buf = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    it.due = cyc; it.exp = expv(); it.tag = "R1 reset state";
    sb.push_back(it);
    // R7: mode 0, serial writes ignored
    ser5(16'h8000, 5'h13, "R7 loader disabled in mode 0");
    // R8: mode write without addr[0] only loads mode
    wr(16'h4100, 8'h02, "R8 mode write without restore");
    // R2/R6/R4: control 0x13 -> mirror 3, 32 KB, 4 KB pattern
    ser5(16'h8000, 5'h13, "R2 R6 control load");
    ser5(16'hE000, 5'h0B, "R4 program bank in 32 KB layout");
    ser5(16'hA000, 5'h15, "R5 pattern low register");
    ser5(16'hC000, 5'h0A, "R5 pattern high register");
    // R3: abort write sets layout bits -> lower window switchable
    wr(16'h8000, 8'h80, "R3 abort sets control bits 3 and 2");
    // R3: partial sequence discarded by abort
    wr(16'h8000, 8'h01, "R3 partial bit");
    wr(16'h8000, 8'h01, "R3 partial bit");
    wr(16'hFFFF, 8'hFE, "R3 abort mid sequence");
    ser5(16'h8000, 5'h08, "R4 R5 upper window switchable, 8 KB pattern");
    ser5(16'h8000, 5'h0D, "R4 R6 lower window switchable, mirror 1");
    ser5(16'h8000, 5'h02, "R6 mirror vertical");
    // R2: the fifth write's address selects the register
    wr(16'h8000, 8'h00, "R2 select by last address");
    wr(16'h8000, 8'h01, "R2 select by last address");
    wr(16'h8000, 8'h01, "R2 select by last address");
    wr(16'h8000, 8'h00, "R2 select by last address");
    wr(16'hE000, 8'h00, "R2 select by last address");
    ser5(16'h8000, 5'h0C, "R4 lower window switchable");
    // R8: restore write with addr[0], mode 3
    wr(16'h8000, 8'h01, "R8 pending bit before restore");
    wr(16'h4101, 8'h03, "R8 restore control and program");
    ser5(16'hA000, 5'h03, "R8 loader restarted from bit 0");
    // R7: mode 1 disables
    wr(16'h7FFF, 8'h01, "R7 mode 1");
    ser5(16'h8000, 5'h11, "R7 loader disabled in mode 1");
    wr(16'h8000, 8'h80, "R7 abort ignored in mode 1");
    idle(4);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog expired: got hang expected completion");
    end
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 unchecked items: got %0d expected 0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule